// File: doc/BRIEF.md
# Cube Multistage Switching Network

This block steers one data word per lane per cycle across a power-of-two set of lanes through a cascade of log2(N) stages of two-input, two-output switch boxes. Stage k joins each lane with the lane whose index differs only in bit k. Every box passes its pair straight, swaps it, or copies one of its two inputs onto both outputs. The stages are purely combinational. A single output register adds one cycle of latency and carries a valid flag beside the data.

Box settings are held in two control tables. The first table has one code per stage. The second table has one row per stage, with a code for each box. A mode input chooses which table drives the boxes, and switching it takes effect at once. Both tables are written through a strobe, a table select, a stage index and a control word. A write changes routing for data presented in the cycle after the write.

The network is blocking. A host that wants a given permutation or multicast pattern must work out the codes itself. The block only applies the codes it is given.

Top module: `cube_net`

## Requirements
- R1: After reset, out_valid is 0, out_data is all zeros, and every entry of both control tables holds the straight code.
- R2: out_valid equals the in_valid of the previous cycle.
- R3: out_data loads the routed lanes only in a cycle where in_valid is 1. When in_valid is 0, out_data keeps its value whatever in_data carries.
- R4: Box code encoding. 2'b00 is straight. 2'b01 is exchange. 2'b10 is upper broadcast: the pair's lower-index lane drives both outputs. 2'b11 is lower broadcast: the higher-index lane drives both outputs. When every effective code is straight, out_data equals the in_data of the previous valid cycle.
- R5: Stage k pairs lane i with lane i XOR (1<<k). Stage 0 acts on in_data first, and stage n-1 acts last. Lane l occupies in_data[16*l +: 16].
- R6: With ctl_mode = 0, the stage code of stage k sets every box of stage k.
- R7: With ctl_mode = 1, box b of stage k takes bits [2b+1:2b] of row k. Box b is the box whose lower lane is b with a 0 bit inserted at bit position k.
- R8: When ctl_we = 1 and ctl_tbl = 0, ctl_word[1:0] is written to stage code ctl_idx. When ctl_tbl = 1, all of ctl_word is written to row ctl_idx. The other table is left unchanged. Data presented in the same cycle as the write is routed with the old codes. Data presented in the following cycle is routed with the new codes.
- R9: A write whose ctl_idx is not below the stage count (3 by default) changes neither table.
- R10: ctl_mode acts combinationally on the stored tables, so toggling it selects the other table without any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_mode | input | 1 | 0 selects per-stage codes, 1 selects per-box codes |
| ctl_we | input | 1 | Control table write strobe |
| ctl_tbl | input | 1 | 0 writes the stage table, 1 writes the box row table |
| ctl_idx | input | 2 | Stage index of the write |
| ctl_word | input | 8 | Code, or row of box codes, to write |
| in_valid | input | 1 | Input lanes carry data |
| in_data | input | 128 | Eight 16-bit input lanes, lane 0 in the low bits |
| out_valid | output | 1 | Registered valid |
| out_data | output | 128 | Eight 16-bit registered output lanes |

## Verification
The assertions assume that reset is applied for at least one clock before any traffic. They also assume that ctl_idx, ctl_tbl and ctl_word are settled whenever ctl_we is high at an edge. The load checks take for granted that an index at or above the stage count is a legal input the block must ignore. The bench drives every input half a cycle away from the sampling edge and always holds reset for several cycles first. It programs the tables one write per cycle and exercises out-of-range indices on purpose, so all of these assumptions hold.

// File: rtl/cube_net_pkg.sv
package cube_net_pkg;

    typedef enum logic [1:0] {
        BOX_THRU  = 2'b00,
        BOX_SWAP  = 2'b01,
        BOX_BC_UP = 2'b10,
        BOX_BC_LO = 2'b11
    } box_code_e;

    // lower-index lane of box b in stage k: insert a zero at bit k of b
    function automatic int box_upper_lane(input int b, input int k);
        int hi;
        int lo;
        hi = (b >> k) << (k + 1);
        lo = b & ((1 << k) - 1);
        return hi | lo;
    endfunction

endpackage

// File: rtl/cube_box.sv
module cube_box #(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       code,
    input  logic [WIDTH-1:0] up_in,
    input  logic [WIDTH-1:0] lo_in,
    output logic [WIDTH-1:0] up_out,
    output logic [WIDTH-1:0] lo_out
);
    import cube_net_pkg::*;

    always_comb begin
        case (box_code_e'(code))
            BOX_THRU: begin
                up_out = up_in;
                lo_out = lo_in;
            end
            BOX_SWAP: begin
                up_out = lo_in;
                lo_out = up_in;
            end
            BOX_BC_UP: begin
                up_out = up_in;
                lo_out = up_in;
            end
            default: begin
                up_out = lo_in;
                lo_out = lo_in;
            end
        endcase
    end

endmodule

// File: rtl/cube_stage.sv
module cube_stage #(
    parameter int LANES = 8,
    parameter int WIDTH = 16,
    parameter int STAGE = 0
) (
    input  logic [LANES*WIDTH-1:0]   din,
    input  logic [LANES-1:0]         codes,
    output logic [LANES*WIDTH-1:0]   dout
);
    localparam int BOXES = LANES / 2;
    localparam int SPAN  = 1 << STAGE;

    for (genvar b = 0; b < BOXES; b++) begin : g_box
        localparam int UP = cube_net_pkg::box_upper_lane(b, STAGE);
        localparam int LO = UP + SPAN;

        cube_box #(.WIDTH(WIDTH)) u_box (
            .code   (codes[2*b +: 2]),
            .up_in  (din[UP*WIDTH +: WIDTH]),
            .lo_in  (din[LO*WIDTH +: WIDTH]),
            .up_out (dout[UP*WIDTH +: WIDTH]),
            .lo_out (dout[LO*WIDTH +: WIDTH])
        );
    end

endmodule

// File: rtl/cube_ctl_store.sv
module cube_ctl_store #(
    parameter int STAGES = 3,
    parameter int BOXES  = 4,
    parameter int IDXW   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode,
    input  logic                      we,
    input  logic                      tbl,
    input  logic [IDXW-1:0]           idx,
    input  logic [BOXES*2-1:0]        word,
    output logic [STAGES*BOXES*2-1:0] eff_codes
);
    localparam int ROWW = BOXES * 2;

    typedef struct packed {
        logic [STAGES-1:0][1:0]      stg;
        logic [STAGES-1:0][ROWW-1:0] row;
    } tbl_t;

    tbl_t st_d, st_q;
    logic idx_ok;

    assign idx_ok = (int'(idx) < STAGES);

    always_comb begin
        st_d = st_q;
        if (we && idx_ok) begin
            if (tbl) begin
                st_d.row[idx] = word;
            end else begin
                st_d.stg[idx] = word[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stg
        for (genvar b = 0; b < BOXES; b++) begin : g_box
            assign eff_codes[(k*BOXES+b)*2 +: 2] =
                mode ? st_q.row[k][2*b +: 2] : st_q.stg[k];
        end
    end

    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !tbl && idx_ok) |=> (st_q.stg[$past(idx)] == $past(word[1:0]))); // R8
    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tbl && idx_ok) |=> (st_q.row[$past(idx)] == $past(word))); // R8
    AST_BAD_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && idx_ok)) |=> $stable(st_q)); // R9

endmodule

// File: rtl/cube_net.sv
module cube_net #(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_mode,
    input  logic                   ctl_we,
    input  logic                   ctl_tbl,
    input  logic [1:0]             ctl_idx,
    input  logic [LANES-1:0]       ctl_word,
    input  logic                   in_valid,
    input  logic [LANES*WIDTH-1:0] in_data,
    output logic                   out_valid,
    output logic [LANES*WIDTH-1:0] out_data
);
    localparam int STAGES = $clog2(LANES);
    localparam int BOXES  = LANES / 2;
    localparam int BUSW   = LANES * WIDTH;
    localparam int CODEW  = BOXES * 2;

    typedef struct packed {
        logic            vld;
        logic [BUSW-1:0] dat;
    } out_t;

    logic [STAGES*CODEW-1:0] eff_codes;
    logic [BUSW-1:0]         lane_bus [STAGES+1];
    out_t                    out_d, out_q;

    cube_ctl_store #(
        .STAGES (STAGES),
        .BOXES  (BOXES),
        .IDXW   (2)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ctl_mode),
        .we        (ctl_we),
        .tbl       (ctl_tbl),
        .idx       (ctl_idx),
        .word      (ctl_word),
        .eff_codes (eff_codes)
    );

    assign lane_bus[0] = in_data;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        cube_stage #(
            .LANES (LANES),
            .WIDTH (WIDTH),
            .STAGE (k)
        ) u_stage (
            .din   (lane_bus[k]),
            .codes (eff_codes[k*CODEW +: CODEW]),
            .dout  (lane_bus[k+1])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            out_d.dat = lane_bus[STAGES];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.dat;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R3
    AST_STRAIGHT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (eff_codes == '0)) |=> (out_data == $past(in_data))); // R4

endmodule

// File: tb/tb_cube_net.sv
module tb_cube_net;
    localparam int LANES = 8;
    localparam int WIDTH = 16;
    localparam int BUSW  = LANES * WIDTH;
    localparam int NVEC  = 10;

    // {mode, stage codes s2 s1 s0, rows r2 r1 r0}
    localparam logic [30:0] VECS [NVEC] = '{
        {1'b0, 6'b00_00_00, 24'h000000},
        {1'b0, 6'b01_01_01, 24'h000000},
        {1'b0, 6'b10_10_10, 24'h000000},
        {1'b0, 6'b11_11_11, 24'h000000},
        {1'b0, 6'b00_01_00, 24'h123456},
        {1'b1, 6'b01_01_01, 24'h000000},
        {1'b1, 6'b00_00_00, 24'h1BE493},
        {1'b1, 6'b10_01_11, 24'hFF0055},
        {1'b1, 6'b11_11_11, 24'h0FF0A5},
        {1'b0, 6'b11_10_01, 24'h5A5A5A}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_mode = 1'b0;
    logic            ctl_we = 1'b0;
    logic            ctl_tbl = 1'b0;
    logic [1:0]      ctl_idx = '0;
    logic [7:0]      ctl_word = '0;
    logic            in_valid = 1'b0;
    logic [BUSW-1:0] in_data = '0;
    logic            out_valid;
    logic [BUSW-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [5:0]  sh_stg = '0;
    logic [23:0] sh_row = '0;
    logic [BUSW-1:0] held;

    always #5 clk = ~clk;

    cube_net #(.LANES(LANES), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .ctl_we(ctl_we),
        .ctl_tbl(ctl_tbl), .ctl_idx(ctl_idx), .ctl_word(ctl_word),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [BUSW-1:0] pattern(input int s);
        logic [BUSW-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[l*WIDTH +: WIDTH] = 16'(s * 16'h1111 + l * 16'h0123 + 16'h0A0B);
        return v;
    endfunction

    function automatic logic [BUSW-1:0] route(input logic m, input logic [5:0] stg,
                                              input logic [23:0] row, input logic [BUSW-1:0] din);
        logic [BUSW-1:0] cur, nxt;
        cur = din;
        for (int k = 0; k < 3; k++) begin
            for (int l = 0; l < LANES; l++) begin
                int p, up, lo, b;
                logic [1:0] c;
                p  = l ^ (1 << k);
                up = (l < p) ? l : p;
                lo = (l < p) ? p : l;
                b  = ((up >> (k + 1)) << k) | (up % (1 << k));
                c  = m ? row[k*8 + b*2 +: 2] : stg[k*2 +: 2];
                case (c)
                    2'b00: nxt[l*WIDTH +: WIDTH] = cur[l*WIDTH +: WIDTH];
                    2'b01: nxt[l*WIDTH +: WIDTH] = cur[p*WIDTH +: WIDTH];
                    2'b10: nxt[l*WIDTH +: WIDTH] = cur[up*WIDTH +: WIDTH];
                    default: nxt[l*WIDTH +: WIDTH] = cur[lo*WIDTH +: WIDTH];
                endcase
            end
            cur = nxt;
        end
        return cur;
    endfunction

    task automatic check(input string req, input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic t, input logic [1:0] i, input logic [7:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_tbl = t; ctl_idx = i; ctl_word = w;
        if (i < 2'd3) begin
            if (t) sh_row[i*8 +: 8] = w;
            else   sh_stg[i*2 +: 2] = w[1:0];
        end
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic push(input logic [BUSW-1:0] d);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid", BUSW'(out_valid), '0);
        check("R1 out_data", out_data, '0);
        push(pattern(77));
        check("R1 straight tables", out_data, pattern(77));

        // vector walk: R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 3; k++) wr(1'b0, 2'(k), {6'b0, VECS[v][24 + k*2 +: 2]});
            for (int k = 0; k < 3; k++) wr(1'b1, 2'(k), VECS[v][k*8 +: 8]);
            ctl_mode = VECS[v][30];
            push(pattern(v));
            check(VECS[v][30] ? "R7 per-box route" : "R6 R5 per-stage route",
                  out_data, route(ctl_mode, sh_stg, sh_row, pattern(v)));
            check("R2 valid follows", BUSW'(out_valid), BUSW'(1));
        end

        // R10: toggle mode without writes
        ctl_mode = 1'b1;
        push(pattern(20));
        check("R10 mode to rows", out_data, route(1'b1, sh_stg, sh_row, pattern(20)));

        // R3: idle hold
        held = out_data;
        in_valid = 1'b0; in_data = pattern(21);
        @(negedge clk);
        check("R3 hold data", out_data, held);
        check("R2 valid low", BUSW'(out_valid), '0);

        // R8: write and data in the same cycle use the old codes
        ctl_mode = 1'b0;
        wr(1'b0, 2'd0, 8'h00); wr(1'b0, 2'd1, 8'h00); wr(1'b0, 2'd2, 8'h00);
        @(negedge clk);
        ctl_we = 1'b1; ctl_tbl = 1'b0; ctl_idx = 2'd0; ctl_word = 8'h01;
        in_valid = 1'b1; in_data = pattern(30);
        @(negedge clk);
        ctl_we = 1'b0;
        sh_stg[1:0] = 2'b01;
        check("R8 same-cycle old codes", out_data, pattern(30));
        in_data = pattern(31);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 next-cycle new codes", out_data, route(1'b0, sh_stg, sh_row, pattern(31)));

        // R9: out-of-range index ignored
        wr(1'b0, 2'd3, 8'h02);
        wr(1'b1, 2'd3, 8'hFF);
        push(pattern(40));
        check("R9 bad index stage table", out_data, route(1'b0, sh_stg, sh_row, pattern(40)));
        ctl_mode = 1'b1;
        push(pattern(41));
        check("R9 bad index row table", out_data, route(1'b1, sh_stg, sh_row, pattern(41)));

        // R8: row write leaves stage table alone
        wr(1'b1, 2'd2, 8'h66);
        ctl_mode = 1'b0;
        push(pattern(42));
        check("R8 other table unchanged", out_data, route(1'b0, sh_stg, sh_row, pattern(42)));

        summary();
    end

endmodule